// File: doc/BRIEF.md
# Associative Address Translation Unit with Page Protection

This block turns a 32-bit virtual address into a 29-bit physical address by comparing it in one cycle against every entry of two fully associative tables: a small fetch table, used only by instruction fetches, and a larger shared table, used by all accesses. Each entry has its own page size, an address-space tag that a global flag on the entry can bypass, a two-bit access-rights field and a dirty flag. The response, registered one cycle after the request, is the physical address with an ok flag, or an exception code. The code separates misses, rights violations (each split by load or store) and the first write to a clean page.

Software fills both tables through a single write port. When a fetch misses the fetch table but hits the shared table, the hardware copies the matching entry into a fetch-table slot chosen by a free-running pseudo-random sequence. A replacement counter for the shared table advances on every lookup. It wraps at the table size, or earlier at a boundary that software sets.

Top module: `tlb_xlate`

## Requirements
- R1: Each entry holds the tag vaddr[31:10] and a size code: 0 = 1 KB (compares tag bits [31:10]), 1 = 4 KB ([31:12]), 2 = 64 KB ([31:16]), 3 = 1 MB ([31:20]). Tag bits below the page size are ignored.
- R2: An entry matches only if its valid bit is set, its tag agrees under the size mask, and either its global bit is set or its address-space id equals asid_i.
- R3: The address-space id comparison is skipped when single_vm_i and priv_i are both 1, and it is required in every other case.
- R4: paddr_o holds vaddr bits below the page size, and the entry's frame field (paddr[28:10]) above it. Frame bits below the page size are dropped. On any exception paddr_o is 0.
- R5: A fetch (ifetch_i=1) searches the fetch table first and the shared table only when the fetch table misses. A data access searches only the shared table. Within a table the lowest index wins.
- R6: A fetch that misses the fetch table and hits the shared table copies that shared entry into a fetch-table slot, so later fetches of the page use the copy even after the shared entry is rewritten.
- R7: A fetch in privileged mode always passes. In user mode it passes only when rights bit 1 is set, and otherwise raises a load rights fault.
- R8: For a privileged data access, rights values 0 and 2 are read-only, so a store raises a store rights fault. Values 1 and 3 allow stores, but a store to an entry whose dirty bit is clear raises an initial-write exception.
- R9: For a user data access, rights values 0 and 1 fault on both loads and stores. Value 2 faults only on stores. Value 3 allows both, and follows the same dirty-bit rule as R8.
- R10: exc_o codes are 0 for no exception, 1 for a load miss, 2 for a store miss, 3 for a load rights fault, 4 for a store rights fault and 5 for an initial write. A fetch counts as a load. ok_o is 1 exactly when a response carries code 0.
- R11: repl_ctr_o advances by one on every request and holds otherwise. It returns to 0 when the incremented value equals the table size, or equals repl_bound_i when repl_bound_i is nonzero.
- R12: Reset empties both tables and clears the counter and all outputs. rsp_valid_o is 1 exactly in the cycle after a request. When there is no response, ok_o, exc_o and paddr_o are 0.
- R13: A port write (wr_itlb_i selects the fetch table; wr_idx_i selects the slot) takes effect at the clock edge. A lookup in the same cycle as the write sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Lookup request |
| vaddr_i | input | 32 | Virtual address |
| ifetch_i | input | 1 | 1 = instruction fetch, 0 = data access |
| write_i | input | 1 | 1 = store |
| priv_i | input | 1 | 1 = privileged mode |
| asid_i | input | 8 | Current address-space id |
| single_vm_i | input | 1 | Single virtual space mode |
| repl_bound_i | input | 6 | Counter wrap boundary, 0 = none |
| wr_en_i | input | 1 | Entry write strobe |
| wr_itlb_i | input | 1 | 1 = write fetch table, 0 = shared table |
| wr_idx_i | input | 6 | Entry slot (low bits for fetch table) |
| wr_tag_i | input | 22 | Tag, virtual address bits [31:10] |
| wr_asid_i | input | 8 | Entry address-space id |
| wr_ppn_i | input | 19 | Frame, physical address bits [28:10] |
| wr_size_i | input | 2 | Page size code |
| wr_valid_i | input | 1 | Entry valid |
| wr_shared_i | input | 1 | Global bit, bypasses id compare |
| wr_dirty_i | input | 1 | Dirty bit |
| wr_prot_i | input | 2 | Access-rights field |
| rsp_valid_o | output | 1 | Response valid |
| ok_o | output | 1 | Translation allowed |
| paddr_o | output | 29 | Physical address |
| exc_o | output | 3 | Exception code |
| repl_ctr_o | output | 6 | Replacement counter |

## Verification
The risky collisions are a table write and a lookup in the same cycle, and a hardware refill of the fetch table alongside a later rewrite of the shared entry it came from. The bench issues a lookup in the very cycle that loads the matching entry and expects a miss, then repeats it and expects a hit. For the refill it fetches a page once, rewrites the shared entry with a new frame, and expects fetches to return the old frame while data loads return the new one. A behavioural model predicts every response and counter value each clock.

// File: rtl/tlb_pkg.sv
package tlb_pkg;
  localparam int VA_W     = 32;
  localparam int PA_W     = 29;
  localparam int PAGE_LSB = 10;
  localparam int TAG_W    = VA_W - PAGE_LSB;
  localparam int PPN_W    = PA_W - PAGE_LSB;
  localparam int ASID_W   = 8;

  typedef struct packed {
    logic              valid;
    logic              shared;
    logic              dirty;
    logic [1:0]        prot;
    logic [1:0]        size;
    logic [ASID_W-1:0] asid;
    logic [TAG_W-1:0]  tag;
    logic [PPN_W-1:0]  ppn;
  } tlb_entry_t;

  typedef enum logic [2:0] {
    EXC_NONE    = 3'd0,
    EXC_LD_MISS = 3'd1,
    EXC_ST_MISS = 3'd2,
    EXC_LD_PROT = 3'd3,
    EXC_ST_PROT = 3'd4,
    EXC_INIT_WR = 3'd5
  } exc_e;

  // ones on tag bits that take part in the compare
  function automatic logic [TAG_W-1:0] tag_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    tag_mask = {TAG_W{1'b1}};
      2'd1:    tag_mask = {{(TAG_W-2){1'b1}}, 2'b0};
      2'd2:    tag_mask = {{(TAG_W-6){1'b1}}, 6'b0};
      default: tag_mask = {{(TAG_W-10){1'b1}}, 10'b0};
    endcase
  endfunction

  function automatic logic [PPN_W-1:0] ppn_mask(input logic [1:0] sz);
    case (sz)
      2'd0:    ppn_mask = {PPN_W{1'b1}};
      2'd1:    ppn_mask = {{(PPN_W-2){1'b1}}, 2'b0};
      2'd2:    ppn_mask = {{(PPN_W-6){1'b1}}, 6'b0};
      default: ppn_mask = {{(PPN_W-10){1'b1}}, 10'b0};
    endcase
  endfunction
endpackage

// File: rtl/tlb_match_array.sv
module tlb_match_array
  import tlb_pkg::*;
#(
  parameter int N = 4,
  localparam int IDX_W = (N > 1) ? $clog2(N) : 1
) (
  input  logic [TAG_W-1:0]  vtag_i,
  input  logic [ASID_W-1:0] asid_i,
  input  logic              need_asid_i,
  input  tlb_entry_t        ent_i [N],
  output logic              hit_o,
  output logic [IDX_W-1:0]  idx_o,
  output tlb_entry_t        ent_o
);
  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    logic tag_eq, asid_ok;
    assign tag_eq  = ((ent_i[g].tag ^ vtag_i) & tag_mask(ent_i[g].size)) == '0;
    assign asid_ok = ent_i[g].shared || !need_asid_i || (ent_i[g].asid == asid_i);
    assign match[g] = ent_i[g].valid && tag_eq && asid_ok;
  end

  // lowest index wins
  always_comb begin
    idx_o = '0;
    for (int k = N - 1; k >= 0; k--) begin
      if (match[k]) idx_o = IDX_W'(k);
    end
  end

  assign hit_o = |match;
  assign ent_o = ent_i[idx_o];
endmodule

// File: rtl/tlb_perm_check.sv
module tlb_perm_check (
  input  logic       ifetch_i,
  input  logic       write_i,
  input  logic       priv_i,
  input  logic [1:0] prot_i,
  input  logic       dirty_i,
  output logic       fault_o,
  output logic       init_wr_o
);
  logic can_wr, can_rd;

  always_comb begin
    can_rd = priv_i ? 1'b1 : prot_i[1];
    can_wr = priv_i ? prot_i[0] : (prot_i == 2'd3);
    fault_o   = 1'b0;
    init_wr_o = 1'b0;
    if (ifetch_i) begin
      fault_o = !priv_i && !prot_i[1];
    end else if (write_i) begin
      fault_o   = !can_wr;
      init_wr_o = can_wr && !dirty_i;
    end else begin
      fault_o = !can_rd;
    end
  end
endmodule

// File: rtl/tlb_repl_ctr.sv
module tlb_repl_ctr #(
  parameter int N      = 64,
  parameter int SLOT_W = 2,
  localparam int CW    = $clog2(N),
  localparam int LFSR_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              adv_i,
  input  logic [CW-1:0]     bound_i,
  output logic [CW-1:0]     ctr_o,
  output logic [SLOT_W-1:0] slot_o
);
  logic [CW-1:0]     ctr_q;
  logic [CW:0]       nxt;
  logic [LFSR_W-1:0] lfsr_q;
  logic              fb;

  assign nxt = {1'b0, ctr_q} + 1'b1;
  assign fb  = lfsr_q[15] ^ lfsr_q[13] ^ lfsr_q[12] ^ lfsr_q[10];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctr_q  <= '0;
      lfsr_q <= 16'hACE1;
    end else begin
      lfsr_q <= {lfsr_q[LFSR_W-2:0], fb};
      if (adv_i) begin
        if (nxt == (CW+1)'(N) || (bound_i != '0 && nxt == {1'b0, bound_i}))
          ctr_q <= '0;
        else
          ctr_q <= nxt[CW-1:0];
      end
    end
  end

  assign ctr_o  = ctr_q;
  assign slot_o = lfsr_q[SLOT_W-1:0];

  a_r11_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !adv_i |=> $stable(ctr_q));
  a_r11_bound_wrap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && bound_i != '0 && {1'b0, ctr_q} == {1'b0, bound_i} - 1'b1) |=> ctr_q == '0);
endmodule

// File: rtl/tlb_xlate.sv
module tlb_xlate
  import tlb_pkg::*;
#(
  parameter int ITLB_N = 4,
  parameter int UTLB_N = 64,
  localparam int UIDX_W = $clog2(UTLB_N),
  localparam int IIDX_W = (ITLB_N > 1) ? $clog2(ITLB_N) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic [31:0]       vaddr_i,
  input  logic              ifetch_i,
  input  logic              write_i,
  input  logic              priv_i,
  input  logic [7:0]        asid_i,
  input  logic              single_vm_i,
  input  logic [UIDX_W-1:0] repl_bound_i,
  input  logic              wr_en_i,
  input  logic              wr_itlb_i,
  input  logic [UIDX_W-1:0] wr_idx_i,
  input  logic [21:0]       wr_tag_i,
  input  logic [7:0]        wr_asid_i,
  input  logic [18:0]       wr_ppn_i,
  input  logic [1:0]        wr_size_i,
  input  logic              wr_valid_i,
  input  logic              wr_shared_i,
  input  logic              wr_dirty_i,
  input  logic [1:0]        wr_prot_i,
  output logic              rsp_valid_o,
  output logic              ok_o,
  output logic [28:0]       paddr_o,
  output logic [2:0]        exc_o,
  output logic [UIDX_W-1:0] repl_ctr_o
);
  tlb_entry_t itlb_q [ITLB_N];
  tlb_entry_t utlb_q [UTLB_N];
  tlb_entry_t wr_ent, i_ent, u_ent, sel_ent;
  logic [IIDX_W-1:0] i_idx, refill_slot;
  logic [UIDX_W-1:0] u_idx;
  logic i_hit, u_hit, use_i, hit, need_asid, wf, refill;
  logic fault, init_wr;
  exc_e exc_d;
  logic [PA_W-1:0] pa_d;

  assign wr_ent = '{valid: wr_valid_i, shared: wr_shared_i, dirty: wr_dirty_i,
                    prot: wr_prot_i, size: wr_size_i, asid: wr_asid_i,
                    tag: wr_tag_i, ppn: wr_ppn_i};

  assign need_asid = !(single_vm_i && priv_i);

  tlb_match_array #(.N(ITLB_N)) u_imatch (
    .vtag_i(vaddr_i[31:PAGE_LSB]), .asid_i(asid_i), .need_asid_i(need_asid),
    .ent_i(itlb_q), .hit_o(i_hit), .idx_o(i_idx), .ent_o(i_ent));

  tlb_match_array #(.N(UTLB_N)) u_umatch (
    .vtag_i(vaddr_i[31:PAGE_LSB]), .asid_i(asid_i), .need_asid_i(need_asid),
    .ent_i(utlb_q), .hit_o(u_hit), .idx_o(u_idx), .ent_o(u_ent));

  assign use_i   = ifetch_i && i_hit;
  assign hit     = use_i || u_hit;
  assign sel_ent = use_i ? i_ent : u_ent;
  assign wf      = write_i && !ifetch_i;
  assign refill  = req_i && ifetch_i && !i_hit && u_hit;

  tlb_perm_check u_perm (
    .ifetch_i(ifetch_i), .write_i(wf), .priv_i(priv_i),
    .prot_i(sel_ent.prot), .dirty_i(sel_ent.dirty),
    .fault_o(fault), .init_wr_o(init_wr));

  tlb_repl_ctr #(.N(UTLB_N), .SLOT_W(IIDX_W)) u_repl (
    .clk_i(clk_i), .rst_ni(rst_ni), .adv_i(req_i), .bound_i(repl_bound_i),
    .ctr_o(repl_ctr_o), .slot_o(refill_slot));

  always_comb begin
    if (!hit)         exc_d = wf ? EXC_ST_MISS : EXC_LD_MISS;
    else if (fault)   exc_d = wf ? EXC_ST_PROT : EXC_LD_PROT;
    else if (init_wr) exc_d = EXC_INIT_WR;
    else              exc_d = EXC_NONE;
  end

  assign pa_d = {(vaddr_i[PA_W-1:PAGE_LSB] & ~ppn_mask(sel_ent.size)) |
                 (sel_ent.ppn & ppn_mask(sel_ent.size)),
                 vaddr_i[PAGE_LSB-1:0]};

  // fetch table: port write overrides a same-slot refill
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < ITLB_N; k++) itlb_q[k] <= '0;
    end else begin
      if (refill) itlb_q[refill_slot] <= u_ent;
      if (wr_en_i && wr_itlb_i) itlb_q[wr_idx_i[IIDX_W-1:0]] <= wr_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < UTLB_N; k++) utlb_q[k] <= '0;
    end else if (wr_en_i && !wr_itlb_i) begin
      utlb_q[wr_idx_i] <= wr_ent;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rsp_valid_o <= 1'b0;
      ok_o        <= 1'b0;
      exc_o       <= '0;
      paddr_o     <= '0;
    end else begin
      rsp_valid_o <= req_i;
      ok_o        <= req_i && (exc_d == EXC_NONE);
      exc_o       <= req_i ? exc_d : EXC_NONE;
      paddr_o     <= (req_i && exc_d == EXC_NONE) ? pa_d : '0;
    end
  end

  a_r12_rsp_after_req: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> rsp_valid_o);
  a_r12_no_rsp_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !req_i |=> (!rsp_valid_o && !ok_o && exc_o == '0));
  a_r10_ok_iff_no_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsp_valid_o |-> (ok_o == (exc_o == '0)));
  a_r4_offset_kept: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_i |=> (!ok_o || paddr_o[PAGE_LSB-1:0] == $past(vaddr_i[PAGE_LSB-1:0])));
  a_r4_zero_on_exc: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rsp_valid_o && !ok_o) |-> paddr_o == '0);
endmodule

// File: tb/tlb_xlate_test.sv
module tlb_xlate_test;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic req_i = 0, ifetch_i = 0, write_i = 0, priv_i = 1, single_vm_i = 0;
  logic [31:0] vaddr_i = '0;
  logic [7:0]  asid_i = 8'd5;
  logic [5:0]  repl_bound_i = '0;
  logic wr_en_i = 0, wr_itlb_i = 0;
  logic [5:0]  wr_idx_i = '0;
  logic [21:0] wr_tag_i = '0;
  logic [7:0]  wr_asid_i = '0;
  logic [18:0] wr_ppn_i = '0;
  logic [1:0]  wr_size_i = '0, wr_prot_i = '0;
  logic wr_valid_i = 0, wr_shared_i = 0, wr_dirty_i = 0;
  logic rsp_valid_o, ok_o;
  logic [28:0] paddr_o;
  logic [2:0]  exc_o;
  logic [5:0]  repl_ctr_o;

  always #5 clk = ~clk;

  tlb_xlate uut (.clk_i(clk), .rst_ni(rst_ni), .req_i(req_i), .vaddr_i(vaddr_i),
    .ifetch_i(ifetch_i), .write_i(write_i), .priv_i(priv_i), .asid_i(asid_i),
    .single_vm_i(single_vm_i), .repl_bound_i(repl_bound_i), .wr_en_i(wr_en_i),
    .wr_itlb_i(wr_itlb_i), .wr_idx_i(wr_idx_i), .wr_tag_i(wr_tag_i),
    .wr_asid_i(wr_asid_i), .wr_ppn_i(wr_ppn_i), .wr_size_i(wr_size_i),
    .wr_valid_i(wr_valid_i), .wr_shared_i(wr_shared_i), .wr_dirty_i(wr_dirty_i),
    .wr_prot_i(wr_prot_i), .rsp_valid_o(rsp_valid_o), .ok_o(ok_o),
    .paddr_o(paddr_o), .exc_o(exc_o), .repl_ctr_o(repl_ctr_o));

  int total = 0, bad = 0, cyc = 0;

  // behavioural model state
  logic [21:0] ut_tag [64]; logic [7:0] ut_as [64]; logic [18:0] ut_pn [64];
  logic [1:0] ut_sz [64]; logic [1:0] ut_pr [64]; bit ut_v [64], ut_sh [64], ut_d [64];
  logic [21:0] it_tag [4]; logic [7:0] it_as [4]; logic [18:0] it_pn [4];
  logic [1:0] it_sz [4]; logic [1:0] it_pr [4]; bit it_v [4], it_sh [4], it_d [4];
  int  m_ctr;
  bit  e_val, e_ok; logic [28:0] e_pa; logic [2:0] e_exc;

  function automatic int skip_bits(logic [1:0] sz);
    return (sz == 0) ? 0 : (sz == 1) ? 2 : (sz == 2) ? 6 : 10;
  endfunction

  function automatic bit hits(logic [21:0] t, logic [1:0] sz, bit v, bit sh, logic [7:0] a,
                              logic [31:0] va);
    int k = skip_bits(sz);
    bit need = !(single_vm_i && priv_i);
    if (!v) return 0;
    if ((va >> (10 + k)) != ({10'd0, t} >> k)) return 0;
    return sh || !need || (a == asid_i);
  endfunction

  task automatic mdl_reset();
    for (int k = 0; k < 64; k++) begin
      ut_v[k] = 0; ut_tag[k] = 0; ut_as[k] = 0; ut_pn[k] = 0; ut_sz[k] = 0;
      ut_pr[k] = 0; ut_sh[k] = 0; ut_d[k] = 0;
    end
    for (int k = 0; k < 4; k++) begin
      it_v[k] = 0; it_tag[k] = 0; it_as[k] = 0; it_pn[k] = 0; it_sz[k] = 0;
      it_pr[k] = 0; it_sh[k] = 0; it_d[k] = 0;
    end
    m_ctr = 0;
  endtask

  task automatic step(input string tag);
    bit found = 0, from_u = 0, fault = 0, initw = 0, wf;
    int fi = 0, ui = 0;
    logic [1:0] sz = 0, pr = 0; logic [18:0] pn = 0; bit d = 0;
    logic [31:0] om;
    wf = write_i && !ifetch_i;
    e_val = req_i; e_ok = 0; e_pa = 0; e_exc = 0;
    if (req_i) begin
      if (ifetch_i)
        for (int k = 3; k >= 0; k--)
          if (hits(it_tag[k], it_sz[k], it_v[k], it_sh[k], it_as[k], vaddr_i)) begin
            found = 1; fi = k;
          end
      if (found) begin
        sz = it_sz[fi]; pr = it_pr[fi]; pn = it_pn[fi]; d = it_d[fi];
      end else begin
        for (int k = 63; k >= 0; k--)
          if (hits(ut_tag[k], ut_sz[k], ut_v[k], ut_sh[k], ut_as[k], vaddr_i)) begin
            from_u = 1; ui = k;
          end
        if (from_u) begin
          found = 1; sz = ut_sz[ui]; pr = ut_pr[ui]; pn = ut_pn[ui]; d = ut_d[ui];
        end
      end
      if (ifetch_i) fault = !priv_i && pr < 2;
      else if (wf) begin
        if (priv_i ? (pr == 0 || pr == 2) : (pr != 3)) fault = 1;
        else if (!d) initw = 1;
      end else fault = !priv_i && pr < 2;
      if (!found) e_exc = wf ? 3'd2 : 3'd1;
      else if (fault) e_exc = wf ? 3'd4 : 3'd3;
      else if (initw) e_exc = 3'd5;
      else begin
        e_ok = 1;
        om = (32'd1 << (10 + skip_bits(sz))) - 1;
        e_pa = 29'((vaddr_i & om) | (({13'd0, pn} << 10) & ~om));
      end
    end
    @(posedge clk);
    // state updates after the edge, lookup used old contents
    if (req_i && ifetch_i && !(found && !from_u) && from_u) begin
      it_v[0] = 1; it_tag[0] = ut_tag[ui]; it_sz[0] = ut_sz[ui]; it_pr[0] = ut_pr[ui];
      it_pn[0] = ut_pn[ui]; it_d[0] = ut_d[ui]; it_sh[0] = ut_sh[ui]; it_as[0] = ut_as[ui];
    end
    if (wr_en_i) begin
      if (wr_itlb_i) begin
        it_v[wr_idx_i[1:0]] = wr_valid_i; it_tag[wr_idx_i[1:0]] = wr_tag_i;
        it_sz[wr_idx_i[1:0]] = wr_size_i; it_pr[wr_idx_i[1:0]] = wr_prot_i;
        it_pn[wr_idx_i[1:0]] = wr_ppn_i; it_d[wr_idx_i[1:0]] = wr_dirty_i;
        it_sh[wr_idx_i[1:0]] = wr_shared_i; it_as[wr_idx_i[1:0]] = wr_asid_i;
      end else begin
        ut_v[wr_idx_i] = wr_valid_i; ut_tag[wr_idx_i] = wr_tag_i; ut_sz[wr_idx_i] = wr_size_i;
        ut_pr[wr_idx_i] = wr_prot_i; ut_pn[wr_idx_i] = wr_ppn_i; ut_d[wr_idx_i] = wr_dirty_i;
        ut_sh[wr_idx_i] = wr_shared_i; ut_as[wr_idx_i] = wr_asid_i;
      end
    end
    if (req_i) begin
      m_ctr = m_ctr + 1;
      if (m_ctr == 64 || (repl_bound_i != 0 && m_ctr == int'(repl_bound_i))) m_ctr = 0;
    end
    @(negedge clk);
    total++;
    if (rsp_valid_o !== e_val || ok_o !== e_ok || paddr_o !== e_pa || exc_o !== e_exc ||
        repl_ctr_o !== 6'(m_ctr)) begin
      bad++;
      $display("FAIL %s: got v=%0b ok=%0b pa=%h exc=%0d ctr=%0d exp v=%0b ok=%0b pa=%h exc=%0d ctr=%0d",
               tag, rsp_valid_o, ok_o, paddr_o, exc_o, repl_ctr_o,
               e_val, e_ok, e_pa, e_exc, m_ctr);
    end
  endtask

  task automatic look(input string tag, input logic [31:0] va, input bit f, input bit w,
                      input bit p);
    vaddr_i = va; ifetch_i = f; write_i = w; priv_i = p; req_i = 1;
    step(tag);
    req_i = 0;
  endtask

  task automatic put(input bit itl, input int idx, input logic [31:0] va, input logic [7:0] a,
                     input logic [18:0] pn, input logic [1:0] sz, input bit v, input bit sh,
                     input bit d, input logic [1:0] pr);
    wr_itlb_i = itl; wr_idx_i = 6'(idx); wr_tag_i = va[31:10]; wr_asid_i = a;
    wr_ppn_i = pn; wr_size_i = sz; wr_valid_i = v; wr_shared_i = sh; wr_dirty_i = d;
    wr_prot_i = pr; wr_en_i = 1;
  endtask

  task automatic load(input bit itl, input int idx, input logic [31:0] va, input logic [7:0] a,
                      input logic [18:0] pn, input logic [1:0] sz, input bit v, input bit sh,
                      input bit d, input logic [1:0] pr);
    put(itl, idx, va, a, pn, sz, v, sh, d, pr);
    step("R13");
    wr_en_i = 0;
  endtask

  task automatic do_reset();
    rst_ni = 0; req_i = 0; wr_en_i = 0;
    mdl_reset();
    repeat (2) @(posedge clk);
    @(negedge clk); rst_ni = 1;
    total++;
    if (rsp_valid_o !== 0 || ok_o !== 0 || paddr_o !== 0 || exc_o !== 0 || repl_ctr_o !== 0) begin
      bad++;
      $display("FAIL R12: reset state v=%0b ok=%0b pa=%h exc=%0d ctr=%0d exp all 0",
               rsp_valid_o, ok_o, paddr_o, exc_o, repl_ctr_o);
    end
  endtask

  initial begin
    do_reset();
    step("R12");
    // R13: lookup in the write cycle sees the old (empty) table
    put(0, 0, 32'h0040_0000, 8'd5, 19'h12345, 2'd0, 1, 0, 1, 2'd3);
    vaddr_i = 32'h0040_0123; ifetch_i = 0; write_i = 0; priv_i = 1; req_i = 1;
    step("R13"); req_i = 0; wr_en_i = 0;
    look("R13", 32'h0040_0123, 0, 0, 1);
    look("R1", 32'h0040_0400, 0, 0, 1);
    // R1 / R4 size variants
    load(0, 1, 32'h0100_0000, 8'd5, 19'h00401, 2'd1, 1, 0, 1, 2'd3);
    look("R1", 32'h0100_0ABC, 0, 0, 1);
    look("R1", 32'h0100_1000, 0, 0, 1);
    load(0, 2, 32'h0200_0000, 8'd5, 19'h0A03F, 2'd2, 1, 0, 1, 2'd3);
    look("R4", 32'h0200_FFFC, 0, 0, 1);
    look("R1", 32'h0201_0000, 0, 0, 1);
    load(0, 3, 32'h0300_0000, 8'd5, 19'h7FFFF, 2'd3, 1, 0, 1, 2'd3);
    look("R4", 32'h030A_BCDE, 0, 0, 1);
    look("R1", 32'h0310_0000, 0, 1, 1);
    // R2 valid / asid / shared
    load(0, 4, 32'h0500_0000, 8'd5, 19'h00111, 2'd1, 0, 0, 1, 2'd3);
    look("R2", 32'h0500_0010, 0, 0, 1);
    load(0, 5, 32'h0600_0000, 8'd9, 19'h00222, 2'd1, 1, 0, 1, 2'd3);
    look("R2", 32'h0600_0010, 0, 0, 1);
    load(0, 6, 32'h0700_0000, 8'd9, 19'h00333, 2'd1, 1, 1, 1, 2'd3);
    look("R2", 32'h0700_0010, 0, 0, 0);
    // R3 single virtual mode bypass
    single_vm_i = 1;
    look("R3", 32'h0600_0010, 0, 0, 1);
    look("R3", 32'h0600_0020, 0, 0, 0);
    single_vm_i = 0;
    look("R3", 32'h0600_0030, 0, 0, 1);
    // R8 / R9 rights per value and dirty
    for (int p = 0; p < 4; p++) begin
      for (int dd = 0; dd < 2; dd++) begin
        load(0, 8 + p * 2 + dd, 32'h1000_0000 + 32'(p * 2 + dd) * 32'h1000, 8'd5,
             19'h01000 + 19'(p * 8 + dd * 4), 2'd1, 1, 0, bit'(dd), 2'(p));
        look("R8", 32'h1000_0004 + 32'(p * 2 + dd) * 32'h1000, 0, 0, 1);
        look("R8", 32'h1000_0008 + 32'(p * 2 + dd) * 32'h1000, 0, 1, 1);
        look("R9", 32'h1000_000C + 32'(p * 2 + dd) * 32'h1000, 0, 0, 0);
        look("R9", 32'h1000_0010 + 32'(p * 2 + dd) * 32'h1000, 0, 1, 0);
      end
    end
    // R10 miss codes, fetch counts as load
    look("R10", 32'h7000_0000, 0, 0, 1);
    look("R10", 32'h7000_0000, 0, 1, 1);
    look("R10", 32'h7000_0000, 1, 1, 1);
    // R5 fetch table first, data uses shared only
    load(1, 0, 32'h0040_0000, 8'd5, 19'h11111, 2'd0, 1, 0, 1, 2'd3);
    look("R5", 32'h0040_0044, 1, 0, 1);
    look("R5", 32'h0040_0044, 0, 0, 1);
    // R7 fetch rights via fetch-table entries
    for (int p = 0; p < 4; p++) begin
      load(1, 1, 32'h2000_0000, 8'd5, 19'h02000 + 19'(p), 2'd1, 1, 0, 0, 2'(p));
      look("R7", 32'h2000_0100, 1, 0, 0);
      look("R7", 32'h2000_0200, 1, 0, 1);
    end
    // R11 boundary wrap, then full-size wrap
    repl_bound_i = 6'd3;
    for (int k = 0; k < 6; k++) look("R11", 32'h7000_0000, 0, 0, 1);
    step("R11");
    repl_bound_i = 6'd0;
    for (int k = 0; k < 70; k++) look("R11", 32'h0040_0000 + 32'(k), 0, 0, 1);
    // R6 refill from shared table
    do_reset();
    load(0, 5, 32'h0800_0000, 8'd5, 19'h0AAAA, 2'd1, 1, 0, 1, 2'd3);
    look("R6", 32'h0800_0010, 1, 0, 1);
    load(0, 5, 32'h0800_0000, 8'd5, 19'h0BBBB, 2'd1, 1, 0, 1, 2'd3);
    look("R6", 32'h0800_0020, 1, 0, 1);
    look("R6", 32'h0800_0030, 0, 0, 1);
    look("R6", 32'h0800_0040, 1, 0, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      bad++;
      total++;
      $display("FAIL watchdog: got cycle=%0d exp done before 20000", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule